// File: doc/BRIEF.md
# Buffered Serial Master Transmitter

This block drives a serial peripheral link as the clock master and sends bytes out on its data line, most significant bit first. A processor-side write port loads a one-byte holding buffer. When the shifter is free, the buffer moves into the shifter and the buffer-free flag rises again. Software can therefore queue the next byte while the current one is still being sent. A queued byte goes out directly after the previous one, with no idle time between the two transfers.

The serial clock comes from a free-running system-clock prescaler, with a divide ratio of 2, 8, 32 or 128. A transfer may only start on a prescaler period boundary. As a result, the wait between a write and the first serial clock cycle is not fixed: it can take any of as many values as the divide ratio. Clock polarity and clock phase are selectable. The serial clock rests at its polarity level whenever no transfer is running.

Top module: `spi_tx_master`

## Requirements
- R1: After reset, `tx_empty` is 1, `busy` is 0, `mosi` is 0 and `sclk` equals `cpol`.
- R2: A write (`wr_en` high) while `tx_empty` is 1 stores `wr_data`, and `tx_empty` reads 0 from the next cycle.
- R3: A write while `tx_empty` is 0 is ignored: the buffered byte is unchanged, and the ignored value never appears on `mosi`.
- R4: `tx_empty` returns to 1 in the same cycle that the buffered byte enters the shifter. For the first byte of a burst, this is the cycle in which `busy` rises.
- R5: If a byte is queued when the last bit's clock cycle ends, the next transfer starts at once. `busy` stays high throughout, and the next sampling edge follows after exactly one serial clock period.
- R6: `rate_sel` values 0, 1, 2 and 3 set the serial clock period to 2, 8, 32 and 128 system clocks. Each half period is half of that.
- R7: A transfer starts only when the count of clock edges since reset is a multiple of the divide ratio. The delay from the accepting write edge to the start edge is from 1 to ratio cycles.
- R8: Bits go out MSB first. With `cpha`=0, each bit is on `mosi` before the leading `sclk` edge, and the receiver samples on the leading edge. With `cpha`=1, each bit is driven at the leading edge, and the receiver samples on the trailing edge.
- R9: Between transfers, `sclk` is at the `cpol` level and `mosi` is 0.
- R10: `busy` rises when a transfer starts. It falls only when the last bit's clock cycle ends with no byte queued, and `tx_empty` is 1 at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Byte to queue |
| rate_sel | input | 2 | Divide ratio select: 0=2, 1=8, 2=32, 3=128 |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Clock phase: 0 samples on leading edge, 1 on trailing edge |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| tx_empty | output | 1 | Holding buffer can take a byte |
| busy | output | 1 | A transfer is in progress |

## Verification
The bench queues bursts of one to three bytes in all four phase/polarity combinations and at every divide ratio. Write times are staggered, so transfers start at different prescaler phases. It sends a write into a full buffer after each burst. A design that accepted that write would corrupt the queued byte, and the scoreboard would see a wrong or extra byte. The bench measures the spacing of every sampling edge, including the edge across a byte boundary, and counts how many times `busy` rises per burst. A design that left a gap between queued bytes, or that dropped `busy` between them, fails here. The start edge is compared against the prescaler period, and the write-to-start delay against its 1-to-ratio window. A start aligned to the write instead of the prescaler, or a flag released late, is therefore reported.

// File: rtl/spi_tx_master.sv
module spi_tx_master #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    rate_sel,
  input  logic          cpol,
  input  logic          cpha,
  output logic          sclk,
  output logic          mosi,
  output logic          tx_empty,
  output logic          busy
);
  localparam int BW = $clog2(DW);

  logic [6:0]    pre_q;
  logic [7:0]    ratio;
  logic [6:0]    cyc_mask, half_mask;
  logic          cyc_tick, half_tick;
  logic [DW-1:0] hold_q, sh_q;
  logic [BW-1:0] bcnt_q;
  logic          sec_q, active_q;

  assign ratio     = 8'd2 << {rate_sel, 1'b0};
  assign cyc_mask  = ratio[6:0] - 7'd1;
  assign half_mask = ratio[7:1] - 7'd1;
  assign cyc_tick  = (pre_q & cyc_mask) == cyc_mask;
  assign half_tick = (pre_q & half_mask) == half_mask;

  assign busy = active_q;
  assign mosi = active_q & sh_q[DW-1];
  assign sclk = active_q ? (cpol ^ (cpha ? ~sec_q : sec_q)) : cpol;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q    <= '0;
      hold_q   <= '0;
      sh_q     <= '0;
      bcnt_q   <= '0;
      sec_q    <= 1'b0;
      active_q <= 1'b0;
      tx_empty <= 1'b1;
    end else begin
      pre_q <= pre_q + 7'd1;
      if (wr_en && tx_empty) begin
        hold_q   <= wr_data;
        tx_empty <= 1'b0;
      end
      if (!active_q) begin
        if (cyc_tick && !tx_empty) begin
          sh_q     <= hold_q;
          tx_empty <= 1'b1;
          active_q <= 1'b1;
          sec_q    <= 1'b0;
          bcnt_q   <= '0;
        end
      end else if (half_tick) begin
        if (!sec_q) begin
          sec_q <= 1'b1;
        end else begin
          sec_q <= 1'b0;
          if (bcnt_q == BW'(DW - 1)) begin
            if (!tx_empty) begin
              sh_q     <= hold_q;
              tx_empty <= 1'b1;
              bcnt_q   <= '0;
            end else begin
              active_q <= 1'b0;
            end
          end else begin
            sh_q   <= {sh_q[DW-2:0], 1'b0};
            bcnt_q <= bcnt_q + 1'b1;
          end
        end
      end
    end
  end

  assert_write_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && tx_empty) |=> !tx_empty);

  assert_full_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !tx_empty) |=> $stable(hold_q));

  assert_empty_at_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> tx_empty);

  assert_end_only_when_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(tx_empty));

  assert_shift_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !half_tick && $past(rst_n)) |=> $stable(sh_q));
endmodule

// File: tb/spi_tx_master_test.sv
`timescale 1ns/1ps
module spi_tx_master_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] rate_sel = 2'd0;
  logic       cpol = 1'b0;
  logic       cpha = 1'b0;
  logic       sclk, mosi, tx_empty, busy;

  spi_tx_master uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rate_sel(rate_sel), .cpol(cpol), .cpha(cpha),
    .sclk(sclk), .mosi(mosi), .tx_empty(tx_empty), .busy(busy)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int ecount = 0;
  int ratio = 2;
  int first_wr_ec = 0;
  int rises = 0;
  logic [7:0] expq[$];
  logic       done = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) ecount <= 0;
    else ecount <= ecount + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor and scoreboard
  logic       prev_sclk = 1'b0;
  logic       prev_busy = 1'b0;
  logic [7:0] rx = 8'h00;
  int         nbits = 0;
  int         last_ec = -1;
  bit         space_ok = 1'b1;
  int         bad_gap = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && !prev_busy) begin
        rises++;
        check(ecount % ratio == 0, "R7", "start edge modulo ratio", ecount % ratio, 0);
        check(ecount - first_wr_ec >= 1 && ecount - first_wr_ec <= ratio, "R7",
              "write-to-start delay", ecount - first_wr_ec, ratio);
        check(tx_empty == 1'b1, "R4", "tx_empty at start", tx_empty, 1);
        last_ec = -1;
      end
      if (busy && prev_busy &&
          ((!cpha && prev_sclk == cpol && sclk != cpol) ||
           ( cpha && prev_sclk != cpol && sclk == cpol))) begin
        if (last_ec >= 0 && ecount - last_ec != ratio) begin
          space_ok = 1'b0;
          bad_gap = ecount - last_ec;
        end
        last_ec = ecount;
        rx = {rx[6:0], mosi};
        nbits++;
        if (nbits == 8) begin
          if (expq.size() == 0) begin
            check(1'b0, "R3", "unexpected byte", rx, -1);
          end else begin
            logic [7:0] e;
            e = expq.pop_front();
            check(rx == e, "R8", "received byte", rx, e);
          end
          check(space_ok, "R6", "sampling edge spacing (R5 across bytes)",
                space_ok ? ratio : bad_gap, ratio);
          space_ok = 1'b1;
          nbits = 0;
        end
      end
      if (!busy && prev_busy) begin
        check(tx_empty == 1'b1, "R10", "tx_empty when busy falls", tx_empty, 1);
        check(sclk == cpol && mosi == 1'b0, "R9", "idle sclk/mosi",
              {sclk, mosi}, {cpol, 1'b0});
      end
    end
    prev_sclk = sclk;
    prev_busy = busy;
  end

  task automatic put(input logic [7:0] d, input bit first);
    while (!tx_empty) @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    expq.push_back(d);
    if (first) first_wr_ec = ecount + 1;
    @(negedge clk);
    wr_en = 1'b0;
    check(tx_empty == 1'b0, "R2", "tx_empty after write", tx_empty, 0);
  endtask

  task automatic burst(input logic [1:0] rs, input logic pol, input logic pha,
                       input int dly, input int n, input logic [7:0] b0,
                       input logic [7:0] b1, input logic [7:0] b2);
    logic [7:0] bytes [3];
    bytes[0] = b0; bytes[1] = b1; bytes[2] = b2;
    @(negedge clk);
    rate_sel = rs; cpol = pol; cpha = pha;
    ratio = 2 << (2 * rs);
    rises = 0;
    repeat (dly) @(negedge clk);
    for (int i = 0; i < n; i++) put(bytes[i], i == 0);
    // write into a full buffer: must be dropped (R3)
    if (!tx_empty) begin
      wr_en = 1'b1;
      wr_data = 8'hEE;
      @(negedge clk);
      wr_en = 1'b0;
    end
    while (busy || !tx_empty) @(negedge clk);
    repeat (3) @(negedge clk);
    check(rises == 1, "R5", "busy rises per burst", rises, 1);
    check(expq.size() == 0, "R3", "bytes left unsent", expq.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(tx_empty == 1'b1 && busy == 1'b0 && mosi == 1'b0 && sclk == cpol, "R1",
          "reset outputs", {tx_empty, busy, mosi, sclk}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    check(sclk == cpol && !busy, "R9", "idle after reset", sclk, cpol);
    burst(2'd0, 1'b0, 1'b0, 0, 2, 8'hA5, 8'h3C, 8'h00);
    burst(2'd1, 1'b0, 1'b1, 3, 3, 8'h81, 8'h7E, 8'h01);
    burst(2'd2, 1'b1, 1'b0, 11, 2, 8'hC3, 8'h18, 8'h00);
    burst(2'd3, 1'b1, 1'b1, 40, 2, 8'h96, 8'hF0, 8'h00);
    burst(2'd1, 1'b0, 1'b1, 6, 1, 8'h5A, 8'h00, 8'h00);
    burst(2'd3, 1'b0, 1'b0, 77, 1, 8'h0F, 8'h00, 8'h00);
    burst(2'd0, 1'b0, 1'b1, 1, 3, 8'hFF, 8'h00, 8'h80);
    burst(2'd2, 1'b0, 1'b1, 5, 3, 8'h12, 8'h34, 8'h56);
    @(negedge clk);
    cpol = 1'b1;
    @(negedge clk);
    check(sclk == 1'b1, "R9", "idle sclk follows cpol", sclk, 1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule